// File: doc/BRIEF.md
# Serial DAC Write Controller

This block is a host-side master that sends 16-bit words to one of several serial digital-to-analog converters. All of them share one serial clock line and one serial data line, and each has its own active-low chip select. A request carries three things: a data word, the number of valid bits in it, and the index of the target converter. The request is taken on a valid/ready handshake. The controller then runs one complete frame on its own and drives a load strobe afterwards when the mode asks for one.

Every timing quantity is a whole number of system clock cycles and is set by a parameter. These are the serial clock half period, the gap from chip select falling to the first rising clock edge, the gap from chip select rising to the load strobe, the strobe width, and the minimum chip select idle time between frames. When the design is elaborated, it refuses any setting that breaks the converter's limits at the given system clock period. Those limits are:
- serial clock at 50 MHz or below,
- at least 10 ns from chip select falling to the first rising clock edge,
- at least 15 ns for chip select high between frames,
- at least 15 ns from chip select rising to the strobe falling,
- at least 15 ns of strobe low time.

The serial clock toggles only inside a frame, which keeps switching noise away from the converters.

Top module: `dac_serial_writer`

## Requirements
- R1: While reset is held and right after it is released, every chip select is high, the serial clock is low, the load strobe is high and the serial data line is low. The ready output is high once reset is released.
- R2: Each frame shifts out exactly 16 bits, most significant bit first, on the rising edges of the serial clock.
- R3: For a length value from 1 to 15, the low `len` bits of the data word are sent in the top `len` positions and the remaining positions are sent as zeros. Data bits at or above `len` have no effect. A length of 0, or of 16 or more, sends the whole word.
- R4: The serial clock stays low whenever no chip select is active.
- R5: At most one chip select is low at any time. The one that goes low is bit `req_dev` of `cs_n`.
- R6: Inside a frame the serial clock period is 2*HALF_DIV cycles and its high time is HALF_DIV cycles. Serial data changes only together with a falling clock edge or with a change of chip select.
- R7: The first rising clock edge comes exactly SETUP_CYC cycles after chip select falls. Chip select rises HALF_DIV cycles after the last rising clock edge, on the same cycle as the final falling edge.
- R8: In strobe mode (`load_tied` = 0 at acceptance), `ldac_n` falls exactly LD_GAP_CYC cycles after chip select rises and stays low for exactly LD_LOW_CYC cycles. In tied mode (`load_tied` = 1) it never pulses. The strobe is low only while every chip select is high.
- R9: Ready drops on the cycle after a request is accepted. It returns no sooner than CS_IDLE_CYC cycles after chip select rises, so chip select stays high for at least CS_IDLE_CYC cycles between frames, including back-to-back requests.
- R10: The mode input is sampled only at acceptance. A change of `load_tied` during a frame does not affect that frame's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_data | input | WORD_W | Word to send; valid bits in the low positions |
| req_len | input | LEN_W | Number of valid bits (0 means a full word) |
| req_dev | input | IDX_W | Index of the target converter |
| load_tied | input | 1 | 1: no load strobe; 0: pulse the strobe after the frame |
| cs_n | output | NUM_DEV | Decoded active-low chip selects |
| sclk | output | 1 | Gated serial clock |
| sdo | output | 1 | Serial data, MSB first |
| ldac_n | output | 1 | Active-low load strobe |

## Verification
The assertions assume that reset is applied from time zero, that `req_dev` is below NUM_DEV, and that the request fields are held steady while `req_valid` is high and `req_ready` is low. The stimulus changes request fields and `load_tied` only on falling clock edges, and only after the previous request has been accepted. It uses only in-range device indices. Length values outside 0 to 16 are driven on purpose, because the block defines how it handles them.

// File: rtl/dac_serial_writer.sv
module dac_serial_writer #(
  parameter int NUM_DEV     = 4,
  parameter int WORD_W      = 16,
  parameter int CLK_PS      = 4000,
  parameter int HALF_DIV    = 3,
  parameter int SETUP_CYC   = 3,
  parameter int LD_GAP_CYC  = 4,
  parameter int LD_LOW_CYC  = 4,
  parameter int CS_IDLE_CYC = 4,
  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int LEN_W = $clog2(WORD_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [WORD_W-1:0]  req_data,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [IDX_W-1:0]   req_dev,
  input  logic               load_tied,
  output logic [NUM_DEV-1:0] cs_n,
  output logic               sclk,
  output logic               sdo,
  output logic               ldac_n
);

  localparam int M1    = (HALF_DIV > SETUP_CYC) ? HALF_DIV : SETUP_CYC;
  localparam int M2    = (LD_GAP_CYC > LD_LOW_CYC) ? LD_GAP_CYC : LD_LOW_CYC;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int MAXC  = (M3 > CS_IDLE_CYC) ? M3 : CS_IDLE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int BIT_W = $clog2(WORD_W);

  if (HALF_DIV < 1 || SETUP_CYC < 1 || LD_GAP_CYC < 1 || LD_LOW_CYC < 1 ||
      CS_IDLE_CYC < 1 ||
      2 * HALF_DIV * CLK_PS < 20000 || SETUP_CYC * CLK_PS < 10000 ||
      CS_IDLE_CYC * CLK_PS < 15000 || LD_GAP_CYC * CLK_PS < 15000 ||
      LD_LOW_CYC * CLK_PS < 15000) begin : g_bad_timing
    $error("dac_serial_writer: timing parameters violate converter limits");
  end

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_LDGAP, S_LDLOW, S_GAP} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitn;
  logic [WORD_W-1:0] sh, padded;
  logic              tied;

  always_comb begin
    if (req_len == '0 || req_len >= LEN_W'(WORD_W))
      padded = req_data;
    else
      padded = req_data << (LEN_W'(WORD_W) - req_len);
  end

  assign req_ready = (st == S_IDLE);
  assign sdo       = sh[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      tied   <= 1'b0;
      cs_n   <= '1;
      sclk   <= 1'b0;
      ldac_n <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          sh   <= padded;
          tied <= load_tied;
          cs_n <= ~(NUM_DEV'(1) << req_dev);
          cnt  <= CNT_W'(SETUP_CYC - 1);
          bitn <= '0;
          st   <= S_SETUP;
        end
        S_SETUP:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            sclk <= 1'b1;
            cnt  <= CNT_W'(HALF_DIV - 1);
            st   <= S_SHIFT;
          end
        S_SHIFT:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!sclk) begin
            sclk <= 1'b1;
            cnt  <= CNT_W'(HALF_DIV - 1);
          end else begin
            sclk <= 1'b0;
            if (bitn == BIT_W'(WORD_W - 1)) begin
              sh   <= '0;
              cs_n <= '1;
              if (tied) begin
                cnt <= CNT_W'(CS_IDLE_CYC - 1);
                st  <= S_GAP;
              end else begin
                cnt <= CNT_W'(LD_GAP_CYC - 1);
                st  <= S_LDGAP;
              end
            end else begin
              sh   <= sh << 1;
              bitn <= bitn + 1'b1;
              cnt  <= CNT_W'(HALF_DIV - 1);
            end
          end
        S_LDGAP:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            ldac_n <= 1'b0;
            cnt    <= CNT_W'(LD_LOW_CYC - 1);
            st     <= S_LDLOW;
          end
        S_LDLOW:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            ldac_n <= 1'b1;
            cnt    <= CNT_W'(CS_IDLE_CYC - 1);
            st     <= S_GAP;
          end
        S_GAP:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dac_serial_writer_chk.sv
module dac_serial_writer_chk #(
  parameter int NUM_DEV = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [NUM_DEV-1:0] cs_n,
  input logic               sclk,
  input logic               sdo,
  input logic               ldac_n
);

  assert_one_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_clock_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sclk);

  assert_data_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> ($fell(sclk) || !$stable(cs_n)));

  assert_cs_rise_with_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&cs_n) |-> $fell(sclk));

  assert_strobe_outside_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ldac_n |-> (&cs_n));

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

bind dac_serial_writer dac_serial_writer_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .ldac_n(ldac_n)
);

// File: tb/sim_dac_serial_writer.sv
`timescale 1ns/1ps
module sim_dac_serial_writer;
  localparam int ND = 4, WW = 16, HALF = 3, SETUP = 3, LDGAP = 4, LDLOW = 4, IDLE = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, load_tied = 1;
  logic [15:0] req_data = 0;
  logic [4:0] req_len = 0;
  logic [1:0] req_dev = 0;
  logic [ND-1:0] cs_n;
  logic sclk, sdo, ldac_n;

  always #2 clk = ~clk;

  dac_serial_writer #(.NUM_DEV(ND), .WORD_W(WW), .CLK_PS(4000), .HALF_DIV(HALF),
    .SETUP_CYC(SETUP), .LD_GAP_CYC(LDGAP), .LD_LOW_CYC(LDLOW), .CS_IDLE_CYC(IDLE)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .req_len(req_len), .req_dev(req_dev), .load_tied(load_tied),
    .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .ldac_n(ldac_n));

  int n_chk = 0, n_fail = 0;
  int cyc = 0, frames = 0, ld_falls = 0;
  int t_csfall = 0, t_csrise = 0, t_rise = 0, t_ldfall = 0;
  int bits = 0, last_bits = 0, dev = 0, last_dev = 0;
  int setup_m = 0, ldgap_m = 0, ldw_m = 0, rdy_m = 0, min_gap = 1000;
  int stray = 0, multi = 0, bad_per = 0, bad_high = 0, bad_hold = 0, sdo_idle = 0;
  logic [15:0] word = 0, last_word = 0;
  logic p_sclk = 0, p_cs = 0, p_ld = 1, p_rdy = 0;

  always @(negedge clk) begin
    logic cs_any;
    cyc++;
    cs_any = ~&cs_n;
    if (rst_n) begin
      if ($countones(~cs_n) > 1) multi++;
      if (!cs_any && sdo) sdo_idle++;
      if (cs_any && !p_cs) begin
        if (frames > 0 && cyc - t_csrise < min_gap) min_gap = cyc - t_csrise;
        t_csfall = cyc; bits = 0; word = 0;
        for (int i = 0; i < ND; i++) if (!cs_n[i]) dev = i;
      end
      if (sclk && !p_sclk) begin
        if (!cs_any) stray++;
        else begin
          if (bits == 0) setup_m = cyc - t_csfall;
          else if (cyc - t_rise != 2 * HALF) bad_per++;
          word = {word[14:0], sdo};
          bits++;
        end
        t_rise = cyc;
      end
      if (!sclk && p_sclk && cyc - t_rise != HALF) bad_high++;
      if (!cs_any && p_cs) begin
        t_csrise = cyc; frames++;
        last_word = word; last_bits = bits; last_dev = dev;
        if (cyc - t_rise != HALF) bad_hold++;
      end
      if (!ldac_n && p_ld) begin ld_falls++; t_ldfall = cyc; ldgap_m = cyc - t_csrise; end
      if (ldac_n && !p_ld) ldw_m = cyc - t_ldfall;
      if (req_ready && !p_rdy && frames > 0) rdy_m = cyc - t_csrise;
    end
    p_sclk = sclk; p_cs = cs_any; p_ld = ldac_n; p_rdy = req_ready;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_word(input logic [15:0] d, input int len);
    logic [15:0] r;
    if (len == 0 || len >= 16) return d;
    r = 0;
    for (int i = 0; i < len; i++) r[15 - i] = d[len - 1 - i];
    return r;
  endfunction

  task automatic push(input logic [15:0] d, input int len, input int dv, input bit tied);
    @(negedge clk);
    req_data = d; req_len = 5'(len); req_dev = 2'(dv); load_tied = tied; req_valid = 1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic wait_done(input int f0);
    @(negedge clk); #1;
    while (frames == f0 || !req_ready) begin @(negedge clk); #1; end
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(cs_n == '1, "R1", "cs_n in reset", cs_n, 4'hF);
    chk(sclk == 0, "R1", "sclk in reset", sclk, 0);
    chk(ldac_n == 1, "R1", "ldac_n in reset", ldac_n, 1);
    chk(sdo == 0, "R1", "sdo in reset", sdo, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(req_ready == 1, "R1", "ready after reset", req_ready, 1);
    chk(cs_n == '1 && sclk == 0, "R1", "outputs idle after reset", {cs_n, sclk}, 5'h1E);
  endtask

  task automatic t_frame(input logic [15:0] d, input int len, input int dv,
                         input bit tied, input bit flip, input string req);
    int f0 = frames, l0 = ld_falls;
    logic [15:0] e = expect_word(d, len);
    push(d, len, dv, tied);
    @(negedge clk);
    req_valid = 0;
    if (flip) load_tied = ~tied;
    wait_done(f0);
    chk(last_word == e, req, "word sent", last_word, e);
    chk(last_bits == 16, "R2", "bit count", last_bits, 16);
    chk(last_dev == dv, "R5", "selected device", last_dev, dv);
    chk(setup_m == SETUP, "R7", "cs fall to first rise", setup_m, SETUP);
    chk(ld_falls - l0 == (tied ? 0 : 1), flip ? "R10" : "R8", "strobe pulses", ld_falls - l0, tied ? 0 : 1);
    if (!tied) begin
      chk(ldgap_m == LDGAP, "R8", "cs rise to strobe", ldgap_m, LDGAP);
      chk(ldw_m == LDLOW, "R8", "strobe width", ldw_m, LDLOW);
    end
    chk(rdy_m >= IDLE, "R9", "cs rise to ready", rdy_m, IDLE);
  endtask

  task automatic t_back_to_back;
    int f0 = frames;
    min_gap = 1000;
    push(16'h1357, 16, 0, 1);
    push(16'h2468, 16, 1, 1);
    push(16'hFEDC, 16, 2, 1);
    @(negedge clk);
    req_valid = 0;
    wait_done(f0 + 2);
    chk(frames - f0 == 3, "R9", "back-to-back frames", frames - f0, 3);
    chk(min_gap >= IDLE, "R9", "min cs high between frames", min_gap, IDLE);
    chk(last_word == 16'hFEDC && last_dev == 2, "R2", "last back-to-back word", last_word, 16'hFEDC);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_frame(16'hA5C3, 16, 0, 1, 0, "R2");
    t_frame(16'h8001, 16, 1, 0, 0, "R2");
    t_frame(16'h0000, 16, 2, 0, 0, "R2");
    t_frame(16'hFFFF, 16, 3, 1, 0, "R2");
    t_frame(16'hFFFF, 4, 1, 1, 0, "R3");
    t_frame(16'h00B7, 8, 2, 0, 0, "R3");
    t_frame(16'hFABC, 12, 3, 1, 0, "R3");
    t_frame(16'h7FFF, 15, 0, 1, 0, "R3");
    t_frame(16'h0001, 1, 1, 1, 0, "R3");
    t_frame(16'h1234, 0, 2, 1, 0, "R3");
    t_frame(16'h4321, 20, 3, 0, 0, "R3");
    t_frame(16'hC0DE, 16, 0, 0, 1, "R10");
    t_frame(16'hBEEF, 16, 1, 1, 1, "R10");
    t_back_to_back();
    repeat (5) @(negedge clk);
    chk(stray == 0, "R4", "clock edges outside frame", stray, 0);
    chk(multi == 0, "R5", "cycles with several selects", multi, 0);
    chk(bad_per == 0, "R6", "bad clock periods", bad_per, 0);
    chk(bad_high == 0, "R6", "bad clock high times", bad_high, 0);
    chk(bad_hold == 0, "R7", "bad last-edge to cs rise", bad_hold, 0);
    chk(sdo_idle == 0, "R1", "data high while idle", sdo_idle, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule